// File: doc/BRIEF.md
# Synchronous Single-Port SRAM with Selectable Read Latency

This block is a clocked single-port memory for use as a data store, for example as a packet buffer or the main store of a signal processor. The address and all command inputs are captured on the rising clock edge. A write stores any subset of the byte lanes. A read returns one word, and a live mode input chooses one of two read paths. In the direct path the array output reaches the pins in the cycle after the address edge. In the registered path it passes through one more output register first. Counting the address cycle, the first word of a run of reads arrives in 2 cycles on the direct path and in 3 cycles on the registered path. Every further consecutive read then delivers one word per cycle. A separate block outside this one produces sequential burst addresses.

The data bus is split. `wdata` carries write data in. `q` carries read data out, and `q_drive` is the enable of the output drivers. When the drivers are off, `q` reads as zero. The output enable and the sleep input act on the drivers combinationally, with no clock. Sleep also blocks every command while the array keeps its contents.

Top module: `ssram_core`

## Requirements
- R1: Right after reset, and with no read in flight, `q_drive` is 0 and `q` is 0.
- R2: With `pipe_mode`=0, the data of a read captured at edge k appears on `q`, with `q_drive`=1, between edge k and edge k+1. No other cycle drives it.
- R3: With `pipe_mode`=1, the data of a read captured at edge k appears between edge k+1 and edge k+2. No other cycle drives it.
- R4: Reads captured on consecutive edges return their words on consecutive cycles in both modes, giving 2-1-1-1 (direct) or 3-1-1-1 (registered) timing.
- R5: A cycle with `wr_all`=1 writes every byte lane, whatever `wr_bytes` and `byte_strb` hold.
- R6: With `wr_all`=0 and `wr_bytes`=1, only the lanes whose `byte_strb` bit is 1 are written. Lane i is `wdata[i*LW +: LW]`, where LW is 9 when DW is a multiple of 9 and 8 otherwise. The default DW of 36 gives four 9-bit lanes.
- R7: A cycle with `cs`=1 and `wr_all` or `wr_bytes` set is a write, even when it enables no lane, and it never turns on `q_drive`. A cycle with `cs`=1 and neither set is a read.
- R8: A read captured on the edge right after a write to the same address returns the newly written data.
- R9: `oe`=0 turns `q_drive` off and forces `q` to 0 at once, without a clock edge. It changes no stored data.
- R10: While `sleep`=1, `q_drive` is 0. Commands captured during sleep are ignored, and stored data survives sleep.
- R11: A cycle with `cs`=0 neither reads nor writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control registers |
| pipe_mode | input | 1 | 1 selects the registered read path, 0 the direct path |
| cs | input | 1 | Select; a cycle with 0 does nothing |
| addr | input | AW | Word address |
| wr_all | input | 1 | Write all byte lanes |
| wr_bytes | input | 1 | Write the lanes chosen by byte_strb |
| byte_strb | input | NB | Per-lane write strobes |
| oe | input | 1 | Output enable, combinational |
| sleep | input | 1 | Low-power request; blocks commands and drivers |
| wdata | input | DW | Write data |
| q | output | DW | Read data, 0 when not driven |
| q_drive | output | 1 | Output driver enable |

## Verification
The latency assertions assume that `pipe_mode` stays constant for the whole time a read is in flight. For that reason the stimulus changes the mode only after three idle cycles with `cs` low. They also assume the inputs carry known values at every clock edge after reset, so the bench drives every input from time zero. The constrained-random stimulus keeps addresses in a small window so that a write and a later read often hit the same word. It also toggles `oe` and `sleep` between edges, so their combinational effect on the drivers is checked apart from the clocked path.

// File: rtl/ssram_pkg.sv
package ssram_pkg;
   // Lane width: 9-bit lanes when the word holds whole 9-bit lanes, else 8-bit.
   function automatic int lane_width(input int dw);
      return (dw % 9 == 0) ? 9 : 8;
   endfunction
endpackage

// File: rtl/ssram_bank.sv
module ssram_bank #(
   parameter int DW    = 36,
   parameter int DEPTH = 64,
   parameter int AW    = $clog2(DEPTH),
   parameter int LW    = 9,
   parameter int NB    = DW / LW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NB-1:0] lane_we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   initial begin
      assert (NB * LW == DW) else $error("ssram_bank: DW must be a whole number of lanes");
      assert (DEPTH >= 2 && DEPTH <= (1 << AW)) else $error("ssram_bank: bad DEPTH");
   end

   for (genvar i = 0; i < NB; i++) begin : g_lane
      logic [LW-1:0] cells [DEPTH];

      always_ff @(posedge clk) begin
         if (lane_we[i]) cells[waddr] <= wdata[i*LW +: LW];
      end

      assign rdata[i*LW +: LW] = cells[raddr];

      // R6: an enabled lane holds the written value after the edge
      a_r6_lane_store: assert property (@(posedge clk) disable iff (!rst_n)
         lane_we[i] |=> cells[$past(waddr)] == $past(wdata[i*LW +: LW]));
   end
endmodule

// File: rtl/ssram_rdpath.sv
module ssram_rdpath #(
   parameter int DW = 36
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pipe_mode,
   input  logic          rd_q,
   input  logic [DW-1:0] arr_data,
   input  logic          oe,
   input  logic          sleep,
   output logic [DW-1:0] q,
   output logic          q_drive
);
   logic          hold_vld;
   logic [DW-1:0] hold_data;
   logic          sel_vld;
   logic [DW-1:0] sel_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hold_vld <= 1'b0;
      else        hold_vld <= rd_q;
   end

   always_ff @(posedge clk) begin
      if (rd_q) hold_data <= arr_data;
   end

   always_comb begin
      sel_vld  = pipe_mode ? hold_vld  : rd_q;
      sel_data = pipe_mode ? hold_data : arr_data;
   end

   assign q_drive = sel_vld & oe & ~sleep;
   assign q       = q_drive ? sel_data : '0;

   // R9: drivers off means a quiet bus
   a_r9_oe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !oe |-> (!q_drive && q == '0));
   // R10: no drive during sleep
   a_r10_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> !q_drive);
endmodule

// File: rtl/ssram_core.sv
module ssram_core
   import ssram_pkg::*;
#(
   parameter int DW    = 36,
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH),
   localparam int LW   = lane_width(DW),
   localparam int NB   = DW / LW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pipe_mode,
   input  logic          cs,
   input  logic [AW-1:0] addr,
   input  logic          wr_all,
   input  logic          wr_bytes,
   input  logic [NB-1:0] byte_strb,
   input  logic          oe,
   input  logic          sleep,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] q,
   output logic          q_drive
);
   initial begin
      assert (DW >= 8 && DW % LW == 0) else $error("ssram_core: DW must be whole 8- or 9-bit lanes");
   end

   logic          live;
   logic          wr_acc;
   logic          rd_acc;
   logic [NB-1:0] lane_we;
   logic          rd_q;
   logic [AW-1:0] raddr_q;
   logic [DW-1:0] arr_data;

   always_comb begin
      live    = cs & ~sleep;
      wr_acc  = live & (wr_all | wr_bytes);
      rd_acc  = live & ~(wr_all | wr_bytes);
      lane_we = '0;
      if (live) begin
         if (wr_all)        lane_we = '1;
         else if (wr_bytes) lane_we = byte_strb;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_q <= 1'b0;
      else        rd_q <= rd_acc;
   end

   always_ff @(posedge clk) begin
      if (rd_acc) raddr_q <= addr;
   end

   ssram_bank #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .LW(LW), .NB(NB)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .lane_we (lane_we),
      .waddr   (addr),
      .wdata   (wdata),
      .raddr   (raddr_q),
      .rdata   (arr_data)
   );

   ssram_rdpath #(.DW(DW)) u_rdpath (
      .clk       (clk),
      .rst_n     (rst_n),
      .pipe_mode (pipe_mode),
      .rd_q      (rd_q),
      .arr_data  (arr_data),
      .oe        (oe),
      .sleep     (sleep),
      .q         (q),
      .q_drive   (q_drive)
   );

   // R2: direct path drives the cycle after the address edge
   a_r2_flow_latency: assert property (@(posedge clk) disable iff (!rst_n)
      rd_acc ##1 (!pipe_mode && oe && !sleep) |-> q_drive);
   // R3: registered path drives one cycle later
   a_r3_pipe_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_acc && pipe_mode) ##1 pipe_mode ##1 (pipe_mode && oe && !sleep) |-> q_drive);
   // R7: a write never drives the bus (direct path)
   a_r7_write_quiet_flow: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_acc && !pipe_mode) ##1 !pipe_mode |-> !q_drive);
   // R7: a write never drives the bus (registered path)
   a_r7_write_quiet_pipe: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_acc && pipe_mode) ##1 pipe_mode ##1 pipe_mode |-> !q_drive);
   // R11: a deselected cycle changes no lane
   a_r11_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      !cs |-> lane_we == '0);
endmodule

// File: tb/tb_ssram_core.sv
module tb_ssram_core;
   localparam int PERIOD = 10;
   localparam int DW = 36;
   localparam int DEPTH = 64;
   localparam int AW = 6;
   localparam int LW = 9;
   localparam int NB = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pipe_mode = 1'b0;
   logic          cs = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          wr_all = 1'b0;
   logic          wr_bytes = 1'b0;
   logic [NB-1:0] byte_strb = '0;
   logic          oe = 1'b1;
   logic          sleep = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] q;
   logic          q_drive;

   ssram_core #(.DW(DW), .DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .cs(cs), .addr(addr),
      .wr_all(wr_all), .wr_bytes(wr_bytes), .byte_strb(byte_strb), .oe(oe),
      .sleep(sleep), .wdata(wdata), .q(q), .q_drive(q_drive));

   always #(PERIOD/2) clk = ~clk;

   int            nchk = 0;
   int            nerr = 0;
   int            cyc  = 0;
   string         tag  = "R1";
   logic [DW-1:0] model [DEPTH];
   logic          ev [8];
   logic [DW-1:0] ed [8];

   function automatic logic [NB-1:0] mask_of(input logic ga, bw, input logic [NB-1:0] st);
      return ga ? '1 : (bw ? st : '0);
   endfunction

   function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, nw, input logic [NB-1:0] m);
      logic [DW-1:0] r = old;
      for (int i = 0; i < NB; i++) if (m[i]) r[i*LW +: LW] = nw[i*LW +: LW];
      return r;
   endfunction

   task automatic check();
      logic          xd = ev[cyc % 8] && oe && !sleep;
      logic [DW-1:0] xq = xd ? ed[cyc % 8] : '0;
      nchk++;
      if (q_drive !== xd || q !== xq) begin
         nerr++;
         $display("FAIL %s cyc %0d: drive %b q %h, expected drive %b q %h", tag, cyc, q_drive, q, xd, xq);
      end
   endtask

   task automatic step(input logic c, ga, bw, input logic [NB-1:0] st, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic o, s);
      int slot;
      @(negedge clk);
      check();
      cs = c; wr_all = ga; wr_bytes = bw; byte_strb = st; addr = a; wdata = d; oe = o; sleep = s;
      if (c && !s) begin
         if (ga || bw) model[a] = merge(model[a], d, mask_of(ga, bw, st));
         else begin
            slot = (cyc + (pipe_mode ? 2 : 1)) % 8;
            ev[slot] = 1'b1;
            ed[slot] = model[a];
         end
      end
      #1 check();   // R9 R10: oe/sleep act without a clock edge
      ev[cyc % 8] = 1'b0;
      cyc++;
   endtask

   task automatic rd(input logic [AW-1:0] a);
      step(1, 0, 0, '0, a, '0, 1, 0);
   endtask
   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, '0, '0, '0, 1, 0);
   endtask
   task automatic set_mode(input logic m);
      idle(3);
      pipe_mode = m;
   endtask

   task automatic random_run(input int n);
      for (int i = 0; i < n; i++) begin
         int k = $urandom_range(0, 99);
         logic c = ($urandom_range(0, 9) != 0);
         logic ga = (k < 15);
         logic bw = (k >= 15 && k < 45);
         step(c, ga, bw, NB'($urandom), AW'($urandom_range(0, 15)), {$urandom, $urandom} [DW-1:0],
              ($urandom_range(0, 99) < 85), ($urandom_range(0, 99) < 5));
      end
   endtask

   initial begin
      #(PERIOD * 200000);
      nerr++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed));
      for (int i = 0; i < 8; i++) begin ev[i] = 1'b0; ed[i] = '0; end
      for (int i = 0; i < DEPTH; i++) model[i] = '0;
      // R1: reset state
      tag = "R1";
      repeat (3) begin @(negedge clk); check(); end
      rst_n = 1'b1;
      idle(2);
      // preload a window so reads of it are defined
      tag = "R5";
      for (int a = 0; a < 20; a++) step(1, 1, 0, '0, AW'(a), {4'h0, 32'hA000_0000 + a}, 1, 0);

      // direct path
      set_mode(0);
      tag = "R2"; rd(3); rd(5); idle(2);
      tag = "R5"; step(1, 1, 0, 4'b0000, 6'd7, 36'h1_2345_6789, 1, 0); rd(7); idle(2);   // R5 strobes off
      tag = "R6"; step(1, 0, 1, 4'b0101, 6'd7, 36'hF_FFFF_FFFF, 1, 0); rd(7); idle(2);   // R6 lanes 0,2
      tag = "R7"; step(1, 0, 1, 4'b0000, 6'd7, 36'h0, 1, 0); rd(7); idle(2);              // R7 empty write
      tag = "R8"; step(1, 1, 0, '0, 6'd9, 36'hB_EEF0_0001, 1, 0); rd(9); idle(2);          // R8
      tag = "R10"; step(1, 1, 0, '0, 6'd9, 36'h0, 1, 1); step(1, 0, 0, '0, 6'd9, '0, 1, 1);
      idle(1); rd(9); idle(2);                                                              // R10
      tag = "R11"; step(0, 1, 0, '0, 6'd9, 36'h7_7777_7777, 1, 0); rd(9); idle(2);          // R11
      tag = "R9"; step(1, 0, 0, '0, 6'd3, '0, 0, 0); step(0, 0, 0, '0, '0, '0, 0, 0); idle(2);
      tag = "R4"; rd(10); rd(11); rd(12); rd(13); idle(2);
      tag = "R2"; random_run(600);

      // registered path
      set_mode(1);
      tag = "R3"; rd(3); rd(5); idle(3);
      tag = "R4"; rd(14); rd(15); rd(16); rd(17); idle(3);
      tag = "R8"; step(1, 0, 1, 4'b1010, 6'd4, 36'hC_CCCC_CCCC, 1, 0); rd(4); idle(3);      // R8 R6
      tag = "R10"; step(1, 0, 0, '0, 6'd4, '0, 1, 1); idle(1); rd(4); step(0, 0, 0, '0, '0, '0, 1, 1); idle(3);
      tag = "R3"; random_run(600);
      idle(4);

      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end
endmodule